// File: doc/BRIEF.md
# Two-Stage Transmit Digital Gain Control

This block sets the level of an up-sampled I/Q baseband stream before it reaches the modulator and converter stages of a digital transmitter. It scales the stream in two stages. The slow stage multiplies both rails by an unsigned fine gain word and covers about 12 dB of range. The fast stage follows it and attenuates in coarse 6 dB steps, where each step is a one-bit arithmetic right shift with rounding to nearest. A further 6 dB step does not touch the samples. The block reports it on a flag, and a downstream stage uses that flag to turn off its secondary, delayed converter path.

The two stages take new settings at different points. A fine gain word presented with a valid sample is captured at that sample boundary and applies from the following valid sample onwards. A coarse step select applies to the very sample it is presented with. Results appear two clock edges after the input sample, as a one-cycle valid pulse. They are saturated symmetrically, so the most negative code never appears on the outputs.

Top module: `txgain_top`

## Requirements
- R1: After reset, outValid and auxDacOff are low, outI and outQ are zero, and the applied fine gain is unity (all ones).
- R2: The fine stage computes floor(x*(g+1)/2^GAIN_W) for a fine word g. All ones gives unity gain, and 255 (with the default 10-bit word) gives a quarter, or -12 dB.
- R3: Results are saturated symmetrically to +/-(2^(DATA_W-1)-1). The code -2^(DATA_W-1) never appears on outI or outQ, and an input at that code at unity gain comes out as -(2^(DATA_W-1)-1).
- R4: A coarseStep code s in 0..3 shifts the fine result right by s bits with round to nearest, ties toward positive: (v + 2^(s-1)) >>> s for s > 0, and v unchanged for s = 0.
- R5: coarseStep codes 4 to 7 apply a 3-bit shift, as code 3 does, and raise auxDacOff together with that sample's output. Codes 0 to 3 leave auxDacOff low.
- R6: A fine word presented with valid sample n does not affect sample n. It applies from sample n+1 onwards.
- R7: The coarseStep value presented with a valid sample is the one applied to that same sample.
- R8: Each valid input gives exactly one outValid pulse, two rising clock edges later.
- R9: On cycles with inValid low, changes on inI, inQ, fineGain and coarseStep have no effect: the outputs hold their last values and outValid stays low.
- R10: I and Q pass through identical arithmetic with the same gain settings.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Input sample strobe |
| inI | input | DATA_W | Signed in-phase sample |
| inQ | input | DATA_W | Signed quadrature sample |
| fineGain | input | GAIN_W | Unsigned fine gain word (all ones is unity) |
| coarseStep | input | 3 | Coarse step select: 0..3 shifts, 4..7 three shifts plus auxiliary path off |
| outValid | output | 1 | Output sample strobe |
| outI | output | DATA_W | Scaled, saturated in-phase sample |
| outQ | output | DATA_W | Scaled, saturated quadrature sample |
| auxDacOff | output | 1 | Request to disable the secondary converter path for this sample |

## Verification
The scaling path is tried with unity, half and quarter fine words at both signs. These inputs separate a correct floor truncation from rounding, and they expose an off-by-one in the gain word mapping. The coarse shifts are tried with odd and negative values whose correct result depends on round-to-nearest, so that plain truncation or rounding toward zero gives a different answer. Full-scale negative inputs check the symmetric clamp, and a tiny gain on small values checks the floor. Directed sequences change the fine word and the step select on alternating samples, and toggle inputs between valid strobes. These sequences separate the one-sample deferral of the fine word from the immediate effect of the step select.

// File: rtl/txgain_pkg.sv
package txgain_pkg;
  typedef struct packed {
    logic       advance;
    logic [1:0] shiftAmt;
    logic       auxOff;
  } ctrlStrobe_t;
endpackage

// File: rtl/txgain_ctrl.sv
module txgain_ctrl
  import txgain_pkg::*;
#(
  parameter int GAIN_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [GAIN_W-1:0] fineGain,
  input  logic [2:0]        coarseStep,
  output ctrlStrobe_t       strobe,
  output logic [GAIN_W-1:0] gainApplied
);
  // fine word captured at a sample boundary, used from the next sample on
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) gainApplied <= '1;
    else if (inValid) gainApplied <= fineGain;
  end

  // coarse select decoded for the sample presented now
  always_comb begin
    strobe.advance = inValid;
    if (coarseStep[2]) begin
      strobe.shiftAmt = 2'd3;
      strobe.auxOff   = 1'b1;
    end else begin
      strobe.shiftAmt = coarseStep[1:0];
      strobe.auxOff   = 1'b0;
    end
  end
endmodule

// File: rtl/txgain_datapath.sv
module txgain_datapath
  import txgain_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int GAIN_W = 10
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  ctrlStrobe_t              strobe,
  input  logic [GAIN_W-1:0]        gainApplied,
  input  logic signed [DATA_W-1:0] inI,
  input  logic signed [DATA_W-1:0] inQ,
  output logic                     outValid,
  output logic signed [DATA_W-1:0] outI,
  output logic signed [DATA_W-1:0] outQ,
  output logic                     auxDacOff
);
  localparam int PROD_W = DATA_W + GAIN_W + 2;
  localparam int SUM_W  = DATA_W + 1;
  localparam logic signed [PROD_W-1:0] MAX_P = PROD_W'((2 ** (DATA_W - 1)) - 1);
  localparam logic signed [PROD_W-1:0] MIN_P = -MAX_P;

  logic signed [DATA_W-1:0] laneIn  [2];
  logic signed [DATA_W-1:0] fineReg [2];
  logic signed [DATA_W-1:0] laneOut [2];
  logic [1:0] shiftReg;
  logic       auxReg;
  logic       validReg;

  logic signed [PROD_W-1:0] gainMul;
  assign gainMul = $signed(PROD_W'({1'b0, gainApplied}) + PROD_W'(1));
  assign laneIn[0] = inI;
  assign laneIn[1] = inQ;

  for (genvar lane = 0; lane < 2; lane++) begin : g_lane
    logic signed [PROD_W-1:0] prod;
    logic signed [PROD_W-1:0] scaled;
    logic signed [DATA_W-1:0] fineSat;
    logic signed [SUM_W-1:0]  biasSum;
    logic signed [SUM_W-1:0]  shifted;

    always_comb begin
      prod   = PROD_W'(laneIn[lane]) * gainMul;
      scaled = prod >>> GAIN_W;
      if (scaled > MAX_P)      fineSat = DATA_W'(MAX_P);
      else if (scaled < MIN_P) fineSat = DATA_W'(MIN_P);
      else                     fineSat = DATA_W'(scaled);
    end

    always_comb begin
      biasSum = SUM_W'(fineReg[lane]);
      if (shiftReg != 2'd0) biasSum = biasSum + (SUM_W'(1) <<< (shiftReg - 2'd1));
      shifted = biasSum >>> shiftReg;
    end
    assign laneOut[lane] = DATA_W'(shifted);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) fineReg[lane] <= '0;
      else if (strobe.advance) fineReg[lane] <= fineSat;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      auxReg   <= 1'b0;
      validReg <= 1'b0;
    end else begin
      validReg <= strobe.advance;
      if (strobe.advance) begin
        shiftReg <= strobe.shiftAmt;
        auxReg   <= strobe.auxOff;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid  <= 1'b0;
      outI      <= '0;
      outQ      <= '0;
      auxDacOff <= 1'b0;
    end else begin
      outValid <= validReg;
      if (validReg) begin
        outI      <= laneOut[0];
        outQ      <= laneOut[1];
        auxDacOff <= auxReg;
      end
    end
  end
endmodule

// File: rtl/txgain_top.sv
module txgain_top
  import txgain_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int GAIN_W = 10
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     inValid,
  input  logic signed [DATA_W-1:0] inI,
  input  logic signed [DATA_W-1:0] inQ,
  input  logic [GAIN_W-1:0]        fineGain,
  input  logic [2:0]               coarseStep,
  output logic                     outValid,
  output logic signed [DATA_W-1:0] outI,
  output logic signed [DATA_W-1:0] outQ,
  output logic                     auxDacOff
);
  ctrlStrobe_t       strobe;
  logic [GAIN_W-1:0] gainApplied;

  txgain_ctrl #(.GAIN_W(GAIN_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .fineGain(fineGain),
    .coarseStep(coarseStep), .strobe(strobe), .gainApplied(gainApplied)
  );

  txgain_datapath #(.DATA_W(DATA_W), .GAIN_W(GAIN_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .gainApplied(gainApplied),
    .inI(inI), .inQ(inQ), .outValid(outValid), .outI(outI), .outQ(outQ),
    .auxDacOff(auxDacOff)
  );
endmodule

// File: rtl/txgain_chk.sv
module txgain_chk #(
  parameter int DATA_W = 12
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     inValid,
  input logic signed [DATA_W-1:0] inI,
  input logic signed [DATA_W-1:0] inQ,
  input logic [2:0]               coarseStep,
  input logic                     outValid,
  input logic signed [DATA_W-1:0] outI,
  input logic signed [DATA_W-1:0] outQ,
  input logic                     auxDacOff
);
  localparam logic signed [DATA_W-1:0] MOST_NEG = {1'b1, {(DATA_W-1){1'b0}}};

  function automatic int magOf(input logic signed [DATA_W-1:0] v);
    return (v < 0) ? -int'(v) : int'(v);
  endfunction

  // R8: every valid input yields an output strobe two edges later
  a_r8_latency: assert property (@(posedge clk) disable iff (!rstN)
    inValid |-> ##2 outValid);

  // R3: the most negative code never leaves the block
  a_r3_symmetric: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outI != MOST_NEG) && (outQ != MOST_NEG));

  // R9: outputs hold while no new result is produced
  a_r9_hold: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> $stable(outI) && $stable(outQ) && $stable(auxDacOff));

  // R5: auxiliary-off flag follows the step code of the same sample
  a_r5_aux_flag: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (auxDacOff == $past(coarseStep[2], 2)));

  // R2/R4: gain never exceeds unity, so magnitude never grows
  a_r2_no_growth: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (magOf(outI) <= magOf($past(inI, 2))) &&
                 (magOf(outQ) <= magOf($past(inQ, 2))));
endmodule

bind txgain_top txgain_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inI(inI), .inQ(inQ),
  .coarseStep(coarseStep), .outValid(outValid), .outI(outI), .outQ(outQ),
  .auxDacOff(auxDacOff)
);

// File: tb/txgain_top_tb.sv
module txgain_top_tb;
  localparam int DATA_W = 12;
  localparam int GAIN_W = 10;
  localparam int VEC_N  = 14;

  // stimulus: I sample, fine word, step code; expected: I result, aux flag
  localparam int vecX   [VEC_N] = '{1000, -2048, 1000, 1000, -1000, 1001, 7, -7, 2047, 100, 100, -3, 5, -2048};
  localparam int vecG   [VEC_N] = '{1023, 1023, 511, 255, 511, 1023, 1023, 1023, 1023, 1023, 1023, 0, 0, 1023};
  localparam int vecS   [VEC_N] = '{0, 0, 0, 0, 1, 1, 2, 2, 3, 4, 7, 0, 0, 3};
  localparam int vecExp [VEC_N] = '{1000, -2047, 500, 250, -250, 501, 2, -2, 256, 13, 13, -1, 0, -256};
  localparam int vecAux [VEC_N] = '{0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 0, 0, 0};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic signed [DATA_W-1:0] inI = '0;
  logic signed [DATA_W-1:0] inQ = '0;
  logic [GAIN_W-1:0] fineGain = '1;
  logic [2:0] coarseStep = '0;
  logic outValid, auxDacOff;
  logic signed [DATA_W-1:0] outI, outQ;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  txgain_top #(.DATA_W(DATA_W), .GAIN_W(GAIN_W)) u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inI(inI), .inQ(inQ),
    .fineGain(fineGain), .coarseStep(coarseStep), .outValid(outValid),
    .outI(outI), .outQ(outQ), .auxDacOff(auxDacOff)
  );

  // reference arithmetic taken from R2, R3, R4, R5
  function automatic int model(input int x, input int g, input int s);
    int v, sh;
    v = (x * (g + 1)) >>> GAIN_W;
    if (v > 2047) v = 2047;
    if (v < -2047) v = -2047;
    sh = (s > 3) ? 3 : s;
    if (sh > 0) v = (v + (1 << (sh - 1))) >>> sh;
    return v;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic sendSample(input int x, input int q, input int g, input int s);
    @(negedge clk);
    inI = DATA_W'(x); inQ = DATA_W'(q);
    fineGain = GAIN_W'(g); coarseStep = 3'(s);
    inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int qIn;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 outValid", int'(outValid), 0);
    check("R1 outI", int'(outI), 0);
    check("R1 auxDacOff", int'(auxDacOff), 0);
    rstN = 1'b1;
    // R1: applied fine word is unity right after reset
    sendSample(600, 300, 0, 0);
    @(negedge clk);
    check("R1 unity after reset", int'(outI), 600);

    // table walk: R2 R3 R4 R5 R10
    for (int k = 0; k < VEC_N; k++) begin
      qIn = -(vecX[k] / 2);
      sendSample(0, 0, vecG[k], 0);
      @(negedge clk);
      sendSample(vecX[k], qIn, vecG[k], vecS[k]);
      @(negedge clk);
      check("R8 outValid", int'(outValid), 1);
      check("R2/R3/R4 outI", int'(outI), vecExp[k]);
      check("R10 outQ", int'(outQ), model(qIn, vecG[k], vecS[k]));
      check("R5 auxDacOff", int'(auxDacOff), vecAux[k]);
      @(negedge clk);
      check("R8 single pulse", int'(outValid), 0);
    end

    // R6: new fine word not applied to its own sample
    sendSample(0, 0, 1023, 0);
    @(negedge clk);
    sendSample(800, 800, 511, 0);
    @(negedge clk);
    check("R6 same sample old gain", int'(outI), 800);
    sendSample(800, 800, 511, 0);
    @(negedge clk);
    check("R6 next sample new gain", int'(outI), 400);

    // R7: step applies to its own sample, then released
    sendSample(800, 800, 1023, 2);
    @(negedge clk);
    check("R7 step same sample", int'(outI), 100);
    sendSample(800, 800, 1023, 0);
    @(negedge clk);
    check("R7 step removed", int'(outI), 800);

    // R9: toggling inputs without a strobe changes nothing
    sendSample(400, -400, 1023, 5);
    @(negedge clk);
    check("R9 setup", int'(outI), 50);
    inI = 12'sd1500; inQ = 12'sd7; fineGain = '0; coarseStep = 3'd0;
    repeat (4) @(negedge clk);
    check("R9 outValid", int'(outValid), 0);
    check("R9 outI held", int'(outI), 50);
    check("R9 outQ held", int'(outQ), -50);
    check("R9 aux held", int'(auxDacOff), 1);
    // R9: fine word offered while invalid was not captured
    sendSample(1000, 1000, 1023, 0);
    @(negedge clk);
    check("R9 gain not captured", int'(outI), 1000);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule